// File: doc/BRIEF.md
# Dual-Bank CPU Register File with Stack Sequencer

This block holds the working registers of an 8-bit processor core: eight byte registers grouped into four 16-bit pairs (BC, DE, HL and an accumulator/flag pair AF), a complete alternate copy of those four pairs, two 8-bit special registers (interrupt page I and refresh counter R), and four 16-bit words: two index registers IX and IY, the stack pointer SP and the program counter PC. A single command port applies one operation per accepted cycle: byte or word writes, 16-bit increment and decrement, the three exchange operations, and the moves between the accumulator and I or R.

The three stack operations are push, pop and the exchange of a register with the word on top of the stack. They run through a request/acknowledge memory port. While one of them is in flight the command port reports not-ready and holds further commands off. Two read ports, one byte-wide and one word-wide, return the register state chosen by their select inputs. Each output is registered, so it appears one cycle after the select is applied.

Top module: `regbank_top`

## Requirements
- R1: After reset every pair, every alternate pair, I, R, IX, IY and PC read as zero, SP reads 0xFFFF, cmd_ready is 1 and mem_req is 0. Both read ports are registered, so each shows the selected state one cycle later.
- R2: Opcode 1 writes a byte, with cmd_sel codes B=0, C=1, D=2, E=3, H=4, L=5, A=6, F=7, I=8, R=9. Opcode 2 writes a word, with codes BC=0, DE=1, HL=2, AF=3, IX=4, IY=5, SP=6, PC=7. The word port uses the word codes for 0-7 and reads the alternate BC, DE, HL and AF at 8-11. A pair reads as its high byte (B, D, H, A) above its low byte (C, E, L, F).
- R3: Opcode 3 adds 1 and opcode 4 subtracts 1 on the word selected by cmd_sel. Both wrap modulo 65536, with carry and borrow crossing between the two bytes.
- R4: Opcode 5 swaps the active DE and HL and leaves the alternate bank unchanged.
- R5: Opcode 6 swaps the active AF with the alternate AF and changes no other pair.
- R6: Opcode 7 swaps BC, DE and HL each with its own alternate in one cycle and leaves AF and the alternate AF unchanged. A second opcode 7 restores the original contents.
- R7: Opcode 8 copies I into A and opcode 9 copies R into A. Both rewrite F as follows: bit7 takes the value's bit 7, bit6 is set when the value is zero, bit5 and bit3 copy the value's bits, bits 4, 2 and 1 clear, and bit0 (carry) is kept. Opcodes 10 and 11 copy A into I or R and leave F unchanged.
- R8: Opcode 12 (push, cmd_sel word code 0-5) lowers SP by 2 in the accept cycle and then issues one write of the selected word at the new SP.
- R9: Opcode 13 (pop, word code 0-5) reads the word at SP, loads it into the selected register and raises SP by 2.
- R10: Opcode 14 (stack exchange, word code HL=2, IX=4 or IY=5) reads the word at SP and then writes the register's old value to the same address. The register receives the word read, and SP does not change.
- R11: mem_req stays high with a stable mem_addr until mem_ack. cmd_ready is low from acceptance until the final acknowledge. A command presented while cmd_ready is low is not taken and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command will be accepted this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_sel | input | 4 | Register select |
| cmd_data | input | 16 | Write data |
| rd8_sel | input | 4 | Byte read select (byte codes) |
| rd8_data | output | 8 | Registered byte read data |
| rd16_sel | input | 4 | Word read select (word codes, 8-11 alternates) |
| rd16_data | output | 16 | Registered word read data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the pending request |

## Verification
The bench aims at the exchange operations. After each one it reads the alternate copies as well as the active ones. This catches a bulk swap that sends one pair's alternate into a neighbour, a DE/HL swap that also disturbs the alternates, and an AF swap that spills into BC. Increment and decrement are driven across the 0x00FF/0x0100 and 0x0000/0xFFFF boundaries, where a carry that stays inside one byte gives an obviously wrong word. The I/R moves use values chosen to expose a flag byte with a lost carry or an undetected zero. They also check that writing I or R leaves F alone. The stack exchange is checked for a changed SP and for a write-back to a different address. A slowed acknowledge shows whether a command offered while busy gets applied.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,  OP_WR8  = 4'd1,  OP_WR16 = 4'd2,  OP_INC  = 4'd3,
    OP_DEC  = 4'd4,  OP_XDH  = 4'd5,  OP_XAF  = 4'd6,  OP_XALL = 4'd7,
    OP_LDAI = 4'd8,  OP_LDAR = 4'd9,  OP_LDIA = 4'd10, OP_LDRA = 4'd11,
    OP_PUSH = 4'd12, OP_POP  = 4'd13, OP_XSP  = 4'd14, OP_RSV  = 4'd15
  } rb_op_e;

  typedef enum logic [2:0] {
    MS_IDLE, MS_PUSH, MS_POP, MS_XRD, MS_XWR
  } ms_state_e;

  localparam int P_BC = 0;
  localparam int P_DE = 1;
  localparam int P_HL = 2;
  localparam int P_AF = 3;
  localparam int NPAIR = 4;
  localparam int NWORD = 4;

  // flag byte after moving a special register into the accumulator
  function automatic logic [7:0] load_flags(input logic [7:0] v, input logic [7:0] f_old);
    return {v[7], (v == 8'h00), v[5], 1'b0, v[3], 1'b0, 1'b0, f_old[0]};
  endfunction

endpackage

// File: rtl/rb_pair_bank.sv
module rb_pair_bank
  import rb_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr8_en,
  input  logic [2:0]                    wr8_sel,
  input  logic [BW-1:0]                 wr8_data,
  input  logic                          wr16_en,
  input  logic [1:0]                    wr16_sel,
  input  logic [2*BW-1:0]               wr16_data,
  input  logic                          f_we,
  input  logic [BW-1:0]                 f_data,
  input  logic                          sw_dehl,
  input  logic                          sw_af,
  input  logic                          sw_all,
  output logic [NPAIR-1:0][2*BW-1:0]    act_v,
  output logic [NPAIR-1:0][2*BW-1:0]    sh_v
);
  localparam int WW = 2 * BW;

  // low byte held at index lo, high byte at index hi
  logic [BW-1:0] a_lo [NPAIR];
  logic [BW-1:0] a_hi [NPAIR];
  logic [BW-1:0] s_lo [NPAIR];
  logic [BW-1:0] s_hi [NPAIR];

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPAIR; p++) begin
      if (rst) begin
        a_lo[p] <= '0; a_hi[p] <= '0; s_lo[p] <= '0; s_hi[p] <= '0;
      end else if (sw_all && p != P_AF) begin
        a_lo[p] <= s_lo[p]; a_hi[p] <= s_hi[p];
        s_lo[p] <= a_lo[p]; s_hi[p] <= a_hi[p];
      end else if (sw_af && p == P_AF) begin
        a_lo[p] <= s_lo[p]; a_hi[p] <= s_hi[p];
        s_lo[p] <= a_lo[p]; s_hi[p] <= a_hi[p];
      end else if (sw_dehl && (p == P_DE || p == P_HL)) begin
        a_lo[p] <= (p == P_DE) ? a_lo[P_HL] : a_lo[P_DE];
        a_hi[p] <= (p == P_DE) ? a_hi[P_HL] : a_hi[P_DE];
      end else begin
        if (wr16_en && wr16_sel == 2'(p)) begin
          a_lo[p] <= wr16_data[BW-1:0];
          a_hi[p] <= wr16_data[WW-1:BW];
        end
        if (wr8_en && wr8_sel[2:1] == 2'(p)) begin
          if (wr8_sel[0]) a_lo[p] <= wr8_data;
          else            a_hi[p] <= wr8_data;
        end
        if (f_we && p == P_AF) a_lo[p] <= f_data;
      end
    end
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_view
    assign act_v[g] = {a_hi[g], a_lo[g]};
    assign sh_v[g]  = {s_hi[g], s_lo[g]};
  end

  // R4
  dehl_swap_chk: assert property (@(posedge clk) disable iff (rst)
    sw_dehl |=> (act_v[P_DE] == $past(act_v[P_HL])) && (act_v[P_HL] == $past(act_v[P_DE]))
                && (sh_v == $past(sh_v)));

  // R5
  af_swap_iso_chk: assert property (@(posedge clk) disable iff (rst)
    sw_af |=> (act_v[P_BC] == $past(act_v[P_BC])) && (act_v[P_AF] == $past(sh_v[P_AF])));

  // R6
  bulk_swap_chk: assert property (@(posedge clk) disable iff (rst)
    sw_all |=> (act_v[P_DE] == $past(sh_v[P_DE])) && (sh_v[P_HL] == $past(act_v[P_HL]))
               && (act_v[P_AF] == $past(act_v[P_AF])));

endmodule

// File: rtl/rb_special.sv
module rb_special
  import rb_pkg::*;
#(
  parameter int              BW     = 8,
  parameter logic [2*BW-1:0] SP_RST = '1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         i_we,
  input  logic                         r_we,
  input  logic [BW-1:0]                b_data,
  input  logic                         wr16_en,
  input  logic [1:0]                   wr16_sel,
  input  logic [2*BW-1:0]              wr16_data,
  input  logic                         sp_we,
  input  logic [2*BW-1:0]              sp_data,
  output logic [BW-1:0]                i_v,
  output logic [BW-1:0]                r_v,
  output logic [NWORD-1:0][2*BW-1:0]   w_v
);
  localparam int WW    = 2 * BW;
  localparam int SP_IX = 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      i_v <= '0;
      r_v <= '0;
    end else begin
      if (i_we) i_v <= b_data;
      if (r_we) r_v <= b_data;
    end
  end

  // index 0 IX, 1 IY, 2 SP, 3 PC
  for (genvar k = 0; k < NWORD; k++) begin : g_word
    localparam logic [WW-1:0] RV = (k == SP_IX) ? SP_RST : '0;
    logic [WW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                 q <= RV;
      else if (k == SP_IX && sp_we)            q <= sp_data;
      else if (wr16_en && wr16_sel == 2'(k))   q <= wr16_data;
    end
    assign w_v[k] = q;
  end

  // R10
  sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sp_we && !(wr16_en && wr16_sel == 2'(SP_IX))) |=> $stable(w_v[SP_IX]));

endmodule

// File: rtl/rb_mem_seq.sv
module rb_mem_seq
  import rb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_push,
  input  logic          go_pop,
  input  logic          go_xchg,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] out_val,
  input  logic [2:0]    tgt,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          ld_en,
  output logic [2:0]    ld_sel,
  output logic [DW-1:0] ld_data,
  output logic          sp_inc
);
  ms_state_e     st;
  logic [DW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= MS_IDLE; mem_we <= 1'b0; mem_addr <= '0;
      mem_wdata <= '0; ld_sel <= '0; hold <= '0;
    end else begin
      unique case (st)
        MS_IDLE: begin
          if (go_push) begin
            st <= MS_PUSH; mem_we <= 1'b1; mem_addr <= base_addr; mem_wdata <= out_val;
          end else if (go_pop) begin
            st <= MS_POP; mem_we <= 1'b0; mem_addr <= base_addr; ld_sel <= tgt;
          end else if (go_xchg) begin
            st <= MS_XRD; mem_we <= 1'b0; mem_addr <= base_addr;
            mem_wdata <= out_val; ld_sel <= tgt;
          end
        end
        MS_PUSH, MS_POP, MS_XWR: if (mem_ack) st <= MS_IDLE;
        MS_XRD: if (mem_ack) begin
          hold <= mem_rdata; st <= MS_XWR; mem_we <= 1'b1;
        end
        default: st <= MS_IDLE;
      endcase
    end
  end

  assign mem_req = (st != MS_IDLE);
  assign busy    = mem_req;
  assign ld_en   = mem_ack && (st == MS_POP || st == MS_XWR);
  assign ld_data = (st == MS_POP) ? mem_rdata : hold;
  assign sp_inc  = mem_ack && (st == MS_POP);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10
  xchg_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (st == MS_XRD && mem_ack) |=> (mem_req && mem_we && mem_addr == $past(mem_addr)));

endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import rb_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [3:0]        cmd_sel,
  input  logic [2*BW-1:0]   cmd_data,
  input  logic [3:0]        rd8_sel,
  output logic [BW-1:0]     rd8_data,
  input  logic [3:0]        rd16_sel,
  output logic [2*BW-1:0]   rd16_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [2*BW-1:0]   mem_addr,
  output logic [2*BW-1:0]   mem_wdata,
  input  logic [2*BW-1:0]   mem_rdata,
  input  logic              mem_ack
);
  localparam int WW  = 2 * BW;
  localparam int SPW = 2;

  rb_op_e op;
  logic   busy, fire;
  logic [NPAIR-1:0][WW-1:0] act_v, sh_v;
  logic [NWORD-1:0][WW-1:0] w_v;
  logic [BW-1:0] i_v, r_v;

  logic          w8_en, f_we, i_we, r_we, w16_en, sp_we;
  logic          sw_dehl, sw_af, sw_all, go_push, go_pop, go_xchg;
  logic [2:0]    w8_sel, w16_sel, ld_sel;
  logic [BW-1:0] w8_data, f_data, b_data;
  logic [WW-1:0] w16_data, sp_data, cur16, base_addr, ld_data;
  logic          ld_en, sp_inc;

  assign op        = rb_op_e'(cmd_op);
  assign cmd_ready = !busy;
  assign fire      = cmd_valid && !busy;
  assign cur16     = cmd_sel[2] ? w_v[cmd_sel[1:0]] : act_v[cmd_sel[1:0]];

  always_comb begin
    w8_en = 1'b0; w8_sel = '0; w8_data = '0; f_we = 1'b0; f_data = '0;
    i_we = 1'b0; r_we = 1'b0; b_data = act_v[P_AF][WW-1:BW];
    w16_en = 1'b0; w16_sel = cmd_sel[2:0]; w16_data = cmd_data;
    sp_we = 1'b0; sp_data = w_v[SPW];
    sw_dehl = 1'b0; sw_af = 1'b0; sw_all = 1'b0;
    go_push = 1'b0; go_pop = 1'b0; go_xchg = 1'b0; base_addr = w_v[SPW];
    if (fire) begin
      unique case (op)
        OP_WR8: begin
          if (!cmd_sel[3]) begin
            w8_en = 1'b1; w8_sel = cmd_sel[2:0]; w8_data = cmd_data[BW-1:0];
          end else begin
            b_data = cmd_data[BW-1:0];
            i_we   = (cmd_sel[2:0] == 3'd0);
            r_we   = (cmd_sel[2:0] == 3'd1);
          end
        end
        OP_WR16: w16_en = 1'b1;
        OP_INC:  begin w16_en = 1'b1; w16_data = cur16 + WW'(1); end
        OP_DEC:  begin w16_en = 1'b1; w16_data = cur16 - WW'(1); end
        OP_XDH:  sw_dehl = 1'b1;
        OP_XAF:  sw_af   = 1'b1;
        OP_XALL: sw_all  = 1'b1;
        OP_LDAI, OP_LDAR: begin
          w8_en   = 1'b1; w8_sel = 3'd6;
          w8_data = (op == OP_LDAI) ? i_v : r_v;
          f_we    = 1'b1;
          f_data  = load_flags(w8_data, act_v[P_AF][BW-1:0]);
        end
        OP_LDIA: i_we = 1'b1;
        OP_LDRA: r_we = 1'b1;
        OP_PUSH: if (cmd_sel <= 4'd5) begin
          go_push = 1'b1; sp_we = 1'b1;
          sp_data = w_v[SPW] - WW'(2); base_addr = sp_data;
        end
        OP_POP:  go_pop  = (cmd_sel <= 4'd5);
        OP_XSP:  go_xchg = (cmd_sel == 4'd2 || cmd_sel == 4'd4 || cmd_sel == 4'd5);
        default: ;
      endcase
    end
    if (ld_en) begin
      w16_en = 1'b1; w16_sel = ld_sel; w16_data = ld_data;
    end
    if (sp_inc) begin
      sp_we = 1'b1; sp_data = w_v[SPW] + WW'(2);
    end
  end

  rb_pair_bank #(.BW(BW)) pairs_i (
    .clk, .rst,
    .wr8_en(w8_en), .wr8_sel(w8_sel), .wr8_data(w8_data),
    .wr16_en(w16_en && !w16_sel[2]), .wr16_sel(w16_sel[1:0]), .wr16_data(w16_data),
    .f_we, .f_data, .sw_dehl, .sw_af, .sw_all, .act_v, .sh_v
  );

  rb_special #(.BW(BW)) spec_i (
    .clk, .rst, .i_we, .r_we, .b_data,
    .wr16_en(w16_en && w16_sel[2]), .wr16_sel(w16_sel[1:0]), .wr16_data(w16_data),
    .sp_we, .sp_data, .i_v, .r_v, .w_v
  );

  rb_mem_seq #(.AW(WW), .DW(WW)) seq_i (
    .clk, .rst, .go_push, .go_pop, .go_xchg, .base_addr, .out_val(cur16),
    .tgt(cmd_sel[2:0]), .mem_ack, .mem_rdata, .busy, .mem_req, .mem_we,
    .mem_addr, .mem_wdata, .ld_en, .ld_sel, .ld_data, .sp_inc
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd8_data  <= '0;
      rd16_data <= '0;
    end else begin
      if (!rd8_sel[3])
        rd8_data <= rd8_sel[0] ? act_v[rd8_sel[2:1]][BW-1:0] : act_v[rd8_sel[2:1]][WW-1:BW];
      else if (rd8_sel[2:0] == 3'd0) rd8_data <= i_v;
      else if (rd8_sel[2:0] == 3'd1) rd8_data <= r_v;
      else                           rd8_data <= '0;
      unique case (rd16_sel[3:2])
        2'd0:    rd16_data <= act_v[rd16_sel[1:0]];
        2'd1:    rd16_data <= w_v[rd16_sel[1:0]];
        2'd2:    rd16_data <= sh_v[rd16_sel[1:0]];
        default: rd16_data <= '0;
      endcase
    end
  end

  // R8
  push_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_PUSH && cmd_sel <= 4'd5) |=> (w_v[SPW] == $past(w_v[SPW]) - WW'(2)) && mem_req && mem_we);

  // R9
  pop_sp_chk: assert property (@(posedge clk) disable iff (rst)
    sp_inc |=> (w_v[SPW] == $past(w_v[SPW]) + WW'(2)));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && !ld_en) |=> (act_v == $past(act_v)));

endmodule

// File: tb/regbank_tb.sv
module regbank_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0, cmd_sel = '0;
  logic [15:0] cmd_data = '0;
  logic [3:0]  rd8_sel = '0, rd16_sel = '0;
  logic [7:0]  rd8_data;
  logic [15:0] rd16_data;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int n_cmp = 0, n_bad = 0;
  int ack_delay = 0, wait_cnt = 0;
  logic [15:0] mem_arr [256];
  logic [15:0] last_wr = '0, last_rd = '0;

  always #5 clk = ~clk;

  regbank_top dut_i (
    .clk, .rst, .cmd_valid, .cmd_ready, .cmd_op, .cmd_sel, .cmd_data,
    .rd8_sel, .rd8_data, .rd16_sel, .rd16_data,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack
  );

  // memory model: answers a request after ack_delay idle cycles
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt < ack_delay) wait_cnt <= wait_cnt + 1;
      else begin
        wait_cnt <= 0;
        mem_ack  <= 1'b1;
        if (mem_we) begin mem_arr[mem_addr[7:0]] <= mem_wdata; last_wr <= mem_addr; end
        else begin mem_rdata <= mem_arr[mem_addr[7:0]]; last_rd <= mem_addr; end
      end
    end
  end

  // {op, sel, data, read select, expected}
  localparam int NV = 32;
  localparam logic [43:0] VEC [NV] = '{
    {4'd2, 4'd0, 16'h1234, 4'd0,  16'h1234},
    {4'd1, 4'd6, 16'h0080, 4'd3,  16'h8000},
    {4'd1, 4'd7, 16'h0001, 4'd3,  16'h8001},
    {4'd1, 4'd1, 16'h0056, 4'd0,  16'h1256},
    {4'd2, 4'd1, 16'h00FF, 4'd1,  16'h00FF},
    {4'd3, 4'd1, 16'h0000, 4'd1,  16'h0100},
    {4'd2, 4'd2, 16'h0000, 4'd2,  16'h0000},
    {4'd4, 4'd2, 16'h0000, 4'd2,  16'hFFFF},
    {4'd3, 4'd2, 16'h0000, 4'd2,  16'h0000},
    {4'd2, 4'd2, 16'hABCD, 4'd2,  16'hABCD},
    {4'd5, 4'd0, 16'h0000, 4'd1,  16'hABCD},
    {4'd0, 4'd0, 16'h0000, 4'd2,  16'h0100},
    {4'd0, 4'd0, 16'h0000, 4'd9,  16'h0000},
    {4'd6, 4'd0, 16'h0000, 4'd3,  16'h0000},
    {4'd0, 4'd0, 16'h0000, 4'd11, 16'h8001},
    {4'd0, 4'd0, 16'h0000, 4'd0,  16'h1256},
    {4'd7, 4'd0, 16'h0000, 4'd0,  16'h0000},
    {4'd0, 4'd0, 16'h0000, 4'd8,  16'h1256},
    {4'd0, 4'd0, 16'h0000, 4'd9,  16'hABCD},
    {4'd0, 4'd0, 16'h0000, 4'd10, 16'h0100},
    {4'd0, 4'd0, 16'h0000, 4'd3,  16'h0000},
    {4'd1, 4'd7, 16'h0001, 4'd3,  16'h0001},
    {4'd1, 4'd8, 16'h0028, 4'd3,  16'h0001},
    {4'd8, 4'd0, 16'h0000, 4'd3,  16'h2829},
    {4'd1, 4'd9, 16'h0000, 4'd3,  16'h2829},
    {4'd9, 4'd0, 16'h0000, 4'd3,  16'h0041},
    {4'd1, 4'd6, 16'h0095, 4'd3,  16'h9541},
    {4'd10,4'd0, 16'h0000, 4'd3,  16'h9541},
    {4'd7, 4'd0, 16'h0000, 4'd1,  16'hABCD},
    {4'd4, 4'd0, 16'h0000, 4'd0,  16'h1255},
    {4'd2, 4'd0, 16'h0100, 4'd0,  16'h0100},
    {4'd4, 4'd0, 16'h0000, 4'd0,  16'h00FF}
  };
  // requirement per vector: R2 writes, R3 inc/dec, R4 DE/HL, R5 AF, R6 bulk, R7 I/R moves
  localparam int VREQ [NV] = '{2,2,2,2,2,3,2,3,3,2,4,4,4,5,5,5,6,6,6,6,6,7,7,7,7,7,7,7,6,3,2,3};

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] sel, input logic [15:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_sel = sel; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic rd16(input logic [3:0] s, output logic [15:0] v);
    @(negedge clk); rd16_sel = s;
    @(negedge clk); v = rd16_data;
  endtask

  task automatic rd8(input logic [3:0] s, output logic [7:0] v);
    @(negedge clk); rd8_sel = s;
    @(negedge clk); v = rd8_data;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 ready", {15'd0, cmd_ready}, 16'h0001);
    chk("R1 req",   {15'd0, mem_req},   16'h0000);
    for (int s = 0; s < 12; s++) begin
      rd16(4'(s), v);
      chk("R1 word", v, (s == 6) ? 16'hFFFF : 16'h0000);
    end
    rd8(4'd8, b); chk("R1 I", {8'd0, b}, 16'h0000);
    rd8(4'd9, b); chk("R1 R", {8'd0, b}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][43:40], VEC[i][39:36], VEC[i][35:20]);
      rd16(VEC[i][19:16], v);
      chk($sformatf("R%0d vector %0d", VREQ[i], i), v, VEC[i][15:0]);
    end

    // R7 I/R moves leave F, reach I/R
    rd8(4'd8, b); chk("R7 I from A", {8'd0, b}, 16'h0095);
    issue(4'd11, 4'd0, 16'h0);
    rd8(4'd9, b); chk("R7 R from A", {8'd0, b}, 16'h0095);
    rd16(4'd3, v); chk("R7 F kept", v, 16'h9541);
    // R2 byte order within a pair
    rd8(4'd0, b); chk("R2 B byte", {8'd0, b}, 16'h0000);
    rd8(4'd1, b); chk("R2 C byte", {8'd0, b}, 16'h00FF);
    issue(4'd2, 4'd7, 16'h4321);
    rd16(4'd7, v); chk("R2 PC", v, 16'h4321);

    // R8 push
    issue(4'd2, 4'd6, 16'h0040);
    issue(4'd2, 4'd0, 16'hBEEF);
    issue(4'd12, 4'd0, 16'h0);
    rd16(4'd6, v); chk("R8 SP", v, 16'h003E);
    chk("R8 addr", last_wr, 16'h003E);
    chk("R8 data", mem_arr[8'h3E], 16'hBEEF);

    // R10 stack exchange with HL then IY
    issue(4'd2, 4'd2, 16'h2222);
    issue(4'd14, 4'd2, 16'h0);
    rd16(4'd2, v); chk("R10 HL", v, 16'hBEEF);
    chk("R10 mem", mem_arr[8'h3E], 16'h2222);
    chk("R10 addr", last_wr, 16'h003E);
    rd16(4'd6, v); chk("R10 SP", v, 16'h003E);
    issue(4'd2, 4'd5, 16'h3333);
    issue(4'd14, 4'd5, 16'h0);
    rd16(4'd5, v); chk("R10 IY", v, 16'h2222);
    chk("R10 mem IY", mem_arr[8'h3E], 16'h3333);

    // R9 pop
    issue(4'd13, 4'd4, 16'h0);
    rd16(4'd4, v); chk("R9 IX", v, 16'h3333);
    rd16(4'd6, v); chk("R9 SP", v, 16'h0040);
    chk("R9 addr", last_rd, 16'h003E);

    // R11 busy blocking with slow memory
    ack_delay = 3;
    @(negedge clk);
    cmd_op = 4'd12; cmd_sel = 4'd1; cmd_data = '0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 4'd2; cmd_sel = 4'd0; cmd_data = 16'h9999;
    chk("R11 ready low", {15'd0, cmd_ready}, 16'h0000);
    chk("R11 req high", {15'd0, mem_req}, 16'h0001);
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    ack_delay = 0;
    rd16(4'd0, v); chk("R11 ignored", v, 16'hBEEF);
    chk("R11 push data", mem_arr[8'h3E], 16'hABCD);
    rd16(4'd6, v); chk("R11 SP", v, 16'h003E);

    finish_run();
  end
endmodule